// File: doc/BRIEF.md
# GPIO Interrupt Latch Controller

This block collects a set of general-purpose input pins and four on-chip status events into one latched status word with a combined interrupt output. Each source first passes through a polarity stage that can invert it. It then goes through an optional debouncer, which is advanced by a slow timeout tick that the block derives from the system clock. A sticky latch captures an active source level. A per-source enable decides whether that latched bit drives the interrupt.

The host reads the status word and removes latched bits with a one-cycle, per-bit clear strobe. Edge-triggered interrupts come from inverting a source's polarity after each transition it reports. Without debouncing, a source latches on the next clock edge even when the timeout tick is stopped, so wake-up events work with no slow clock running. All inputs are assumed synchronous to `clk`.

Top module: `irq_latch_ctrl`

## Requirements
- R1: The status word is 13 bits wide with default parameters. Bit 12 is the combined interrupt. Bits 11, 10, 9 and 8 hold `evt_in[3]` (temperature OK), `evt_in[2]` (microphone short), `evt_in[1]` (microphone detect) and `evt_in[0]` (PLL lock). Bits 7:0 hold `gpio_in[7:0]`.
- R2: A source whose `pol_cfg` bit is 0 latches while its input is 1. A source whose `pol_cfg` bit is 1 latches while its input is 0. Toggling the polarity bit after each report therefore gives an interrupt on every edge.
- R3: A latched bit stays set until the host pulses its `clr_pulse` bit for one cycle. The bit is then 0 after that clock edge, provided its source is inactive.
- R4: `irq` and status bit 12 are 1 exactly when at least one latched bit has its `irq_en` bit set. A source with `irq_en` 0 still latches, and its bit is still visible in the status word.
- R5: The combined interrupt cannot be cleared directly. It falls only once every enabled latched bit has been cleared.
- R6: A source with `dbnc_en` 0 latches at the first clock edge at which it is active, whether or not the timeout tick runs.
- R7: A source with `dbnc_en` 1 takes a new level only after that level has been sampled at two consecutive timeout ticks. A pulse much shorter than one tick period is ignored.
- R8: The timeout tick occurs every `DIV_FAST` (16) clocks when `tick_fast` is 1 and every `DIV_SLOW` (64) clocks when it is 0. There are no ticks while `tick_run` is 0, so debounced sources cannot change level while the tick is stopped.
- R9: If a clear strobe and an active source meet on the same bit in the same cycle, the bit stays set.
- R10: While `rst_n` is low at a clock edge, all latched bits, the debouncers and the tick divider return to 0, so the status word and `irq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_in | input | NUM_GPIO | General-purpose input pins |
| evt_in | input | 4 | Internal status events: 0 PLL lock, 1 mic detect, 2 mic short, 3 temperature OK |
| pol_cfg | input | NUM_GPIO+4 | Per-source inversion, indexed like status bits |
| dbnc_en | input | NUM_GPIO+4 | Per-source debounce enable |
| irq_en | input | NUM_GPIO+4 | Per-source interrupt enable |
| tick_run | input | 1 | Runs the timeout tick divider |
| tick_fast | input | 1 | Selects the short tick period |
| clr_pulse | input | NUM_GPIO+4 | One-cycle per-bit clear strobe |
| status | output | NUM_GPIO+5 | Latched status word with the interrupt at the top bit |
| irq | output | 1 | Combined interrupt |

## Verification
A vector table drives a single GPIO, each internal event, inverted sources, masked sources and simultaneous clear-and-set patterns. Comparing each pattern with its predecessor separates stickiness from level following and separates masking from latching. It also shows whether the interrupt falls only when the last enabled bit goes. One source steps through high, inverted, low and inverted again, which shows that a polarity toggle reports both edges. Directed runs on debounced pins contrast a long level, a two-cycle glitch, the fast and slow tick periods and a stopped tick. A non-debounced pin latching while the tick is stopped shows that the bypass is independent of the tick.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt latch controller.
// Assumes the internal events sit directly above the GPIO bits in the status word.
package irq_pkg;
    localparam int NUM_EVT  = 4;
    localparam int EVT_PLL  = 0;
    localparam int EVT_MDET = 1;
    localparam int EVT_MSHT = 2;
    localparam int EVT_TOK  = 3;
endpackage

// File: rtl/irq_tick_gen.sv
// Module: timeout tick divider.
// Emits a one-cycle tick every DIV_FAST or DIV_SLOW clocks, chosen by fast_i.
// Assumes 2 <= DIV_FAST and DIV_FAST <= DIV_SLOW. The count restarts when run_i is low.
module irq_tick_gen #(
    parameter int DIV_SLOW = 64,
    parameter int DIV_FAST = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic tick_o
);
    localparam int CW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
    localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Select the terminal count for the current rate.
    always_comb lim = fast_i ? LIM_FAST : LIM_SLOW;

    // Count clocks and pulse the tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= lim) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R8: a tick is a single cycle, never back to back
    p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/irq_src_filter.sv
// Module: per-source conditioning.
// Applies polarity, then an optional two-tick debouncer.
// Assumes raw_i is synchronous to clk. Output is the active-high "source active" level.
module irq_src_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_i,
    input  logic dbnc_en_i,
    input  logic tick_i,
    output logic act_o
);
    logic cond;
    logic smp_q;
    logic db_q;

    // Invert the pin when its polarity bit is set.
    always_comb cond = raw_i ^ pol_i;

    // Sample on each tick; accept a level seen at two consecutive ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            db_q  <= 1'b0;
        end else if (tick_i) begin
            smp_q <= cond;
            if (cond == smp_q) db_q <= cond;
        end
    end

    // Choose the debounced or the direct level.
    always_comb act_o = dbnc_en_i ? db_q : cond;

    // R7: the debounced level moves only on a timeout tick
    p_db_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(db_q) |-> $past(tick_i));
endmodule

// File: rtl/irq_latch_ctrl.sv
// Module: top of the interrupt latch controller.
// Conditions each GPIO and internal event, latches active sources into sticky bits,
// and ORs the enabled latched bits into the interrupt.
// Assumes all inputs are synchronous to clk; clr_pulse is held for one cycle per clear.
module irq_latch_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_GPIO = 8,
    parameter int DIV_SLOW = 64,
    parameter int DIV_FAST = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_GPIO-1:0]       gpio_in,
    input  logic [NUM_EVT-1:0]        evt_in,
    input  logic [NUM_GPIO+NUM_EVT-1:0] pol_cfg,
    input  logic [NUM_GPIO+NUM_EVT-1:0] dbnc_en,
    input  logic [NUM_GPIO+NUM_EVT-1:0] irq_en,
    input  logic                      tick_run,
    input  logic                      tick_fast,
    input  logic [NUM_GPIO+NUM_EVT-1:0] clr_pulse,
    output logic [NUM_GPIO+NUM_EVT:0] status,
    output logic                      irq
);
    localparam int NUM_SRC = NUM_GPIO + NUM_EVT;

    logic               tick;
    logic [NUM_SRC-1:0] raw_all;
    logic [NUM_SRC-1:0] act;
    logic [NUM_SRC-1:0] lat_q;

    // Place events above the GPIO pins, in status-bit order.
    always_comb raw_all = {evt_in, gpio_in};

    irq_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tick_run),
        .fast_i (tick_fast),
        .tick_o (tick)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_filter u_flt (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_i     (raw_all[i]),
            .pol_i     (pol_cfg[i]),
            .dbnc_en_i (dbnc_en[i]),
            .tick_i    (tick),
            .act_o     (act[i])
        );
    end

    // Sticky latch: clear first, then a live source sets, so the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (lat_q & ~clr_pulse) | act;
    end

    // Combine enabled latched bits into the interrupt.
    always_comb irq = |(lat_q & irq_en);

    // Present the status word with the interrupt on top.
    always_comb status = {irq, lat_q};

    // R3: an uncleared latched bit stays set
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat_q & $past(lat_q & ~clr_pulse)) == $past(lat_q & ~clr_pulse)));

    // R9: a source active during its own clear keeps the bit set
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((act & clr_pulse) != '0) |=> ((lat_q & $past(act & clr_pulse)) == $past(act & clr_pulse)));

    // R2: a bit can only rise after its conditioned source was active
    p_rise_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat_q & ~$past(lat_q) & ~$past(act)) == '0));
endmodule

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  gpio_in = '0;
    logic [3:0]  evt_in = '0;
    logic [11:0] pol_cfg = '0;
    logic [11:0] dbnc_en = '0;
    logic [11:0] irq_en = '0;
    logic        tick_run = 1'b0;
    logic        tick_fast = 1'b0;
    logic [11:0] clr_pulse = '0;
    logic [12:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_latch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .evt_in(evt_in),
        .pol_cfg(pol_cfg), .dbnc_en(dbnc_en), .irq_en(irq_en),
        .tick_run(tick_run), .tick_fast(tick_fast), .clr_pulse(clr_pulse),
        .status(status), .irq(irq)
    );

    // {gpio, evt, pol, irq_en, clr, expected status}
    localparam int NV = 16;
    localparam logic [60:0] VEC [NV] = '{
        {8'h00, 4'h0, 12'h000, 12'hfff, 12'h000, 13'h0000},
        {8'h01, 4'h0, 12'h000, 12'hfff, 12'h000, 13'h1001},
        {8'h00, 4'h1, 12'h000, 12'hfff, 12'h000, 13'h1101},
        {8'h00, 4'h0, 12'h000, 12'hfff, 12'h001, 13'h1100},
        {8'h00, 4'h0, 12'h000, 12'h0ff, 12'h000, 13'h0100},
        {8'h00, 4'h0, 12'h002, 12'h0ff, 12'h000, 13'h1102},
        {8'h02, 4'h0, 12'h002, 12'hfff, 12'h102, 13'h0000},
        {8'h04, 4'h0, 12'h000, 12'hfff, 12'h004, 13'h1004},
        {8'h00, 4'h0, 12'h000, 12'hfff, 12'h004, 13'h0000},
        {8'h00, 4'h8, 12'h000, 12'hfff, 12'h000, 13'h1800},
        {8'h00, 4'h0, 12'h000, 12'hfff, 12'h800, 13'h0000},
        {8'h08, 4'h0, 12'h000, 12'hfff, 12'h000, 13'h1008},
        {8'h08, 4'h0, 12'h008, 12'hfff, 12'h008, 13'h0000},
        {8'h00, 4'h0, 12'h008, 12'hfff, 12'h000, 13'h1008},
        {8'h00, 4'h0, 12'h008, 12'hfff, 12'h008, 13'h1008},
        {8'h00, 4'h0, 12'h000, 12'hfff, 12'h008, 13'h0000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            1, 2, 9:         return "R1";
            0, 5, 11, 12, 13: return "R2";
            3, 8, 14, 15:    return "R3";
            4:               return "R4";
            6, 10:           return "R5";
            default:         return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cycles(3);
        chk("R10", status, 13'h0000);
        chk("R10", {12'h0, irq}, 13'h0);
        rst_n = 1'b1;

        // Table walk: R6 also holds here, tick stopped and no debounce.
        for (int i = 0; i < NV; i++) begin
            gpio_in   = VEC[i][60:53];
            evt_in    = VEC[i][52:49];
            pol_cfg   = VEC[i][48:37];
            irq_en    = VEC[i][36:25];
            clr_pulse = VEC[i][24:13];
            @(posedge clk);
            @(negedge clk);
            chk(vec_tag(i), status, VEC[i][12:0]);
            chk("R4", {12'h0, irq}, {12'h0, status[12]});
        end
        clr_pulse = '0;
        pol_cfg = '0;
        gpio_in = '0;
        irq_en = 12'hfff;

        // R7: debounced pin waits for two ticks (fast rate)
        tick_run = 1'b1; tick_fast = 1'b1; dbnc_en = 12'h030;
        gpio_in = 8'h10;
        cycles(3);
        chk("R7", status, 13'h0000);
        cycles(40);
        chk("R8", status, 13'h1010);
        gpio_in = 8'h00;
        cycles(40);
        clr_pulse = 12'h010; cycles(1); clr_pulse = '0; cycles(1);
        chk("R3", status, 13'h0000);

        // R7: a two-cycle glitch is filtered
        gpio_in = 8'h20; cycles(2); gpio_in = 8'h00;
        cycles(60);
        chk("R7", status, 13'h0000);

        // R8: slow rate needs more than 64 clocks
        tick_fast = 1'b0; dbnc_en = 12'h040; gpio_in = 8'h40;
        cycles(40);
        chk("R8", status, 13'h0000);
        cycles(200);
        chk("R8", status, 13'h1040);
        gpio_in = 8'h00;
        cycles(200);
        clr_pulse = 12'h040; cycles(1); clr_pulse = '0; cycles(1);
        chk("R3", status, 13'h0000);

        // R8: stopped tick blocks debounced pins; R6: direct pins still latch
        tick_run = 1'b0; dbnc_en = 12'h080; gpio_in = 8'h80;
        cycles(200);
        chk("R8", status, 13'h0000);
        gpio_in = 8'h81;
        cycles(2);
        chk("R6", status, 13'h1001);

        // R10: reset clears a latched state
        gpio_in = 8'h00;
        rst_n = 1'b0; cycles(1);
        chk("R10", status, 13'h0000);
        chk("R10", {12'h0, irq}, 13'h0);
        rst_n = 1'b1; cycles(2);
        chk("R10", status, 13'h0000);

        finish_run();
    end
endmodule